// File: doc/BRIEF.md
# Receive Buffer Space Tracker

This block keeps track of how much room is left in the receive buffer currently being filled. The room is held as a 32-bit count of 16-bit words. Each word the receive path stores lowers the count. When a packet ends, the block compares what is left with a programmable threshold. The threshold is normally set to the size of the largest packet that can arrive. If the remaining count is below that threshold, the next packet might not fit. The block then raises a request for a fresh buffer and holds it until the descriptor logic acknowledges it. Because of this, a packet is never split between two buffers.

Software loads the count as two 16-bit halves and the threshold as one 16-bit value, all through a small write port. On acknowledge, the count reloads from the value of the fetched descriptor. The bus mode input selects how much one write consumes:
- In 16-bit mode a write stores one word.
- In 32-bit mode a write stores two words, and the lowest bit of the threshold is taken as zero so that the comparison stays on a long-word boundary.

If a packet runs past the end of the buffer, the count stops at zero and a sticky overflow flag is set.

Control is a two-state machine:
- **ST_FILL**: word strobes are accepted and packet ends are evaluated.
- **ST_WAIT_BUF**: the request output is high, and word and packet-end strobes are ignored.

The transition FILL_TO_WAIT happens on a packet end whose resulting count is below the effective threshold. The transition WAIT_TO_FILL happens on an acknowledge.

Top module: `rxbuf_floor_tracker`

## Requirements
- R1: After reset the remaining count is 0, the threshold reads 0x2F8 (760 words), the request is low and the overflow flag is low.
- R2: In 16-bit mode (`bus32`=0), each accepted word strobe lowers the remaining count by 1. The result is visible on the cycle after the strobe.
- R3: In 32-bit mode (`bus32`=1), each accepted word strobe lowers the remaining count by 2. A borrow carries from the low half into the high half.
- R4: A word strobe that would take the count below zero leaves the count at 0 and sets the overflow flag. The flag stays set until an acknowledge loads a new count or software writes either half of the count. A threshold write does not clear it.
- R5: A packet-end strobe in ST_FILL raises the request on the next cycle if the resulting count is strictly below the effective threshold. The request stays high until acknowledged.
- R6: A packet-end strobe whose resulting count is equal to or above the effective threshold leaves the request low.
- R7: In 32-bit mode the effective threshold is the threshold with bit 0 cleared. In 16-bit mode it is the full threshold.
- R8: An acknowledge while the request is high loads the count from `desc_count` and clears the overflow flag. The request drops on the next cycle.
- R9: Register writes decode `reg_sel` as follows:
  - 0 writes count bits 15:0.
  - 1 writes count bits 31:16.
  - 2 writes the threshold.
  - 3 changes nothing.
  A count write in the same cycle as a word strobe takes priority over the decrement.
- R10: While the request is high, word strobes and packet-end strobes have no effect on the count or the request.
- R11: When a word strobe and a packet-end strobe arrive in the same cycle, the comparison uses the count after that word.
- R12: An acknowledge while the request is low has no effect. The request never rises without a packet-end strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus32 | input | 1 | 1 = 32-bit mode, 0 = 16-bit mode |
| word_wr | input | 1 | One bus write of packet data stored |
| pkt_end | input | 1 | Current packet finished |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 count low, 1 count high, 2 threshold, 3 none |
| reg_wdata | input | 16 | Register write data |
| new_buf_ack | input | 1 | Descriptor fetched; `desc_count` valid |
| desc_count | input | 32 | Word count of the new buffer |
| new_buf_req | output | 1 | Fresh buffer needed before the next packet |
| remaining | output | 32 | Words left in the current buffer |
| threshold | output | 16 | Programmed threshold value |
| overflow | output | 1 | Sticky: a packet ran past the buffer end |

## Verification
The assertions check the following on every cycle:
- the per-write step size in each mode;
- the clamp at zero and the stickiness of the overflow flag;
- that the request holds until acknowledged and rises only after a packet end;
- that the count freezes while waiting;
- the reload on acknowledge.

The following can only be shown by the bench scenarios:
- the reset values;
- the long-word masking of the threshold seen at the exact boundary;
- the borrow across the two halves;
- the priority of a register write over a same-cycle decrement;
- the same-cycle word and packet-end case.

// File: rtl/rbt_pkg.sv
package rbt_pkg;

    typedef enum logic [0:0] {
        ST_FILL     = 1'b0,
        ST_WAIT_BUF = 1'b1
    } rbt_state_e;

    typedef enum logic [1:0] {
        SEL_CNT_LO = 2'd0,
        SEL_CNT_HI = 2'd1,
        SEL_FLOOR  = 2'd2,
        SEL_NONE   = 2'd3
    } rbt_sel_e;

endpackage

// File: rtl/rbt_counter.sv
module rbt_counter #(
    parameter int HALF_W     = 16,
    parameter int NUM_HALVES = 2,
    localparam int CNT_W     = HALF_W * NUM_HALVES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus32,
    input  logic                  dec_en,
    input  logic                  load_desc,
    input  logic [CNT_W-1:0]      desc_val,
    input  logic [NUM_HALVES-1:0] wr_half,
    input  logic [HALF_W-1:0]     wdata,
    output logic [CNT_W-1:0]      cnt_q,
    output logic [CNT_W-1:0]      cnt_next,
    output logic                  ovf_q
);

    logic [CNT_W-1:0] step;
    logic             ovf_next;

    assign step = bus32 ? CNT_W'(2) : CNT_W'(1);

    always_comb begin
        cnt_next = cnt_q;
        ovf_next = ovf_q;
        if (load_desc) begin
            cnt_next = desc_val;
            ovf_next = 1'b0;
        end else if (|wr_half) begin
            for (int h = 0; h < NUM_HALVES; h++) begin
                if (wr_half[h]) cnt_next[h*HALF_W +: HALF_W] = wdata;
            end
            ovf_next = 1'b0;
        end else if (dec_en) begin
            if (cnt_q < step) begin
                cnt_next = '0;
                ovf_next = 1'b1;
            end else begin
                cnt_next = cnt_q - step;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_next;
            ovf_q <= ovf_next;
        end
    end

endmodule

// File: rtl/rbt_floor_cmp.sv
module rbt_floor_cmp #(
    parameter int          CNT_W     = 32,
    parameter int          THR_W     = 16,
    parameter logic [15:0] THR_RESET = 16'h02F8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus32,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [THR_W-1:0] thr_q,
    output logic             below
);

    logic [THR_W-1:0] thr_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      thr_q <= THR_W'(THR_RESET);
        else if (thr_we) thr_q <= thr_wdata;
    end

    // long-word mode compares against an even threshold
    assign thr_eff = bus32 ? {thr_q[THR_W-1:1], 1'b0} : thr_q;
    assign below   = cnt_in < CNT_W'(thr_eff);

endmodule

// File: rtl/rbt_ctrl.sv
module rbt_ctrl
    import rbt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_end,
    input  logic ack,
    input  logic below,
    output logic req,
    output logic accept
);

    rbt_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:     if (pkt_end && below) state_d = ST_WAIT_BUF;  // FILL_TO_WAIT
            ST_WAIT_BUF: if (ack)              state_d = ST_FILL;      // WAIT_TO_FILL
            default:     state_d = ST_FILL;
        endcase
    end

    always_comb begin
        req    = 1'b0;
        accept = 1'b0;
        unique case (state_q)
            ST_FILL:     accept = 1'b1;
            ST_WAIT_BUF: req    = 1'b1;
            default:     accept = 1'b0;
        endcase
    end

endmodule

// File: rtl/rxbuf_floor_tracker.sv
module rxbuf_floor_tracker
    import rbt_pkg::*;
#(
    parameter int          HALF_W     = 16,
    parameter int          NUM_HALVES = 2,
    parameter int          THR_W      = 16,
    parameter logic [15:0] THR_RESET  = 16'h02F8,
    localparam int         CNT_W      = HALF_W * NUM_HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus32,
    input  logic              word_wr,
    input  logic              pkt_end,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [HALF_W-1:0] reg_wdata,
    input  logic              new_buf_ack,
    input  logic [CNT_W-1:0]  desc_count,
    output logic              new_buf_req,
    output logic [CNT_W-1:0]  remaining,
    output logic [THR_W-1:0]  threshold,
    output logic              overflow
);

    logic                  accept;
    logic                  below;
    logic [NUM_HALVES-1:0] wr_half;
    logic [CNT_W-1:0]      cnt_next;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half_dec
        assign wr_half[h] = reg_wr && (reg_sel == 2'(h));
    end

    rbt_counter #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus32     (bus32),
        .dec_en    (word_wr && accept),
        .load_desc (new_buf_ack && !accept),
        .desc_val  (desc_count),
        .wr_half   (wr_half),
        .wdata     (reg_wdata),
        .cnt_q     (remaining),
        .cnt_next  (cnt_next),
        .ovf_q     (overflow)
    );

    rbt_floor_cmp #(.CNT_W(CNT_W), .THR_W(THR_W), .THR_RESET(THR_RESET)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus32     (bus32),
        .thr_we    (reg_wr && (reg_sel == SEL_FLOOR)),
        .thr_wdata (THR_W'(reg_wdata)),
        .cnt_in    (cnt_next),
        .thr_q     (threshold),
        .below     (below)
    );

    rbt_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .pkt_end (pkt_end),
        .ack     (new_buf_ack),
        .below   (below),
        .req     (new_buf_req),
        .accept  (accept)
    );

endmodule

// File: rtl/rbt_checker.sv
module rbt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus32,
    input logic        word_wr,
    input logic        pkt_end,
    input logic        reg_wr,
    input logic [1:0]  reg_sel,
    input logic        new_buf_ack,
    input logic [31:0] desc_count,
    input logic        new_buf_req,
    input logic [31:0] remaining,
    input logic [15:0] threshold,
    input logic        overflow
);

    logic        cnt_write;
    logic [31:0] floor_eff;
    assign cnt_write = reg_wr && (reg_sel == 2'd0 || reg_sel == 2'd1);
    assign floor_eff = {16'd0, threshold[15:1], bus32 ? 1'b0 : threshold[0]};

    assert_step16_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_wr && !new_buf_req && !bus32 && !cnt_write && remaining != 0
        |=> remaining == $past(remaining) - 32'd1);

    assert_step32_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_wr && !new_buf_req && bus32 && !cnt_write && remaining >= 32'd2
        |=> remaining == $past(remaining) - 32'd2);

    assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_wr && !new_buf_req && !cnt_write && remaining < (bus32 ? 32'd2 : 32'd1)
        |=> remaining == 0 && overflow);

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !(new_buf_req && new_buf_ack) && !cnt_write |=> overflow);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        new_buf_req && !new_buf_ack |=> new_buf_req);

    assert_req_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end && !new_buf_req && !word_wr && !reg_wr && remaining < floor_eff
        |=> new_buf_req);

    assert_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end && !new_buf_req && !word_wr && !reg_wr && remaining >= floor_eff
        |=> !new_buf_req);

    assert_ack_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        new_buf_req && new_buf_ack
        |=> !new_buf_req && remaining == $past(desc_count) && !overflow);

    assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        new_buf_req && !new_buf_ack && !cnt_write |=> $stable(remaining));

    assert_no_spurious_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !new_buf_req && !pkt_end |=> !new_buf_req);

endmodule

bind rxbuf_floor_tracker rbt_checker u_rbt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus32       (bus32),
    .word_wr     (word_wr),
    .pkt_end     (pkt_end),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .new_buf_ack (new_buf_ack),
    .desc_count  (desc_count),
    .new_buf_req (new_buf_req),
    .remaining   (remaining),
    .threshold   (threshold),
    .overflow    (overflow)
);

// File: tb/rxbuf_floor_tracker_test.sv
module rxbuf_floor_tracker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus32 = 1'b0;
    logic        word_wr = 1'b0;
    logic        pkt_end = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic        new_buf_ack = 1'b0;
    logic [31:0] desc_count = 32'd0;
    logic        new_buf_req;
    logic [31:0] remaining;
    logic [15:0] threshold;
    logic        overflow;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    rxbuf_floor_tracker uut (
        .clk(clk), .rst_n(rst_n), .bus32(bus32), .word_wr(word_wr),
        .pkt_end(pkt_end), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .new_buf_ack(new_buf_ack),
        .desc_count(desc_count), .new_buf_req(new_buf_req),
        .remaining(remaining), .threshold(threshold), .overflow(overflow)
    );

    typedef struct packed {
        logic        m32;
        logic [31:0] start;
        logic [7:0]  nwords;
        logic [15:0] thr;
        logic [31:0] exp_rem;
        logic        exp_req;
        logic        exp_ovf;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'd1000,       8'd10, 16'd760,    32'd990,        1'b0, 1'b0}, // R2
        '{1'b0, 32'd765,        8'd5,  16'd760,    32'd760,        1'b0, 1'b0}, // R6 equal
        '{1'b0, 32'd765,        8'd6,  16'd760,    32'd759,        1'b1, 1'b0}, // R5
        '{1'b1, 32'd1000,       8'd10, 16'd760,    32'd980,        1'b0, 1'b0}, // R3
        '{1'b1, 32'd770,        8'd5,  16'd760,    32'd760,        1'b0, 1'b0}, // R3 R6
        '{1'b1, 32'd760,        8'd0,  16'd761,    32'd760,        1'b0, 1'b0}, // R7 masked
        '{1'b0, 32'd760,        8'd0,  16'd761,    32'd760,        1'b1, 1'b0}, // R7 full
        '{1'b0, 32'd3,          8'd5,  16'd760,    32'd0,          1'b1, 1'b1}, // R4
        '{1'b1, 32'd3,          8'd2,  16'd760,    32'd0,          1'b1, 1'b1}, // R4 odd
        '{1'b1, 32'd4,          8'd2,  16'd0,      32'd0,          1'b0, 1'b0}, // R4 exact
        '{1'b0, 32'h0001_0003,  8'd5,  16'd760,    32'h0000_FFFE,  1'b0, 1'b0}, // R9 borrow
        '{1'b1, 32'h0002_0000,  8'd1,  16'hFFFF,   32'h0001_FFFE,  1'b0, 1'b0}  // R3 R7
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [15:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic pulse_words(input int n);
        for (int i = 0; i < n; i++) begin
            word_wr = 1'b1;
            tick();
        end
        word_wr = 1'b0;
    endtask

    task automatic pulse_end();
        pkt_end = 1'b1;
        tick();
        pkt_end = 1'b0;
    endtask

    task automatic give_ack(input logic [31:0] val);
        new_buf_ack = 1'b1; desc_count = val;
        tick();
        new_buf_ack = 1'b0;
    endtask

    task automatic load_count(input logic [31:0] val);
        wr_reg(2'd0, val[15:0]);
        wr_reg(2'd1, val[31:16]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset values
        check("R1 remaining", remaining, 32'd0);
        check("R1 threshold", {16'd0, threshold}, 32'h2F8);
        check("R1 req", {31'd0, new_buf_req}, 32'd0);
        check("R1 overflow", {31'd0, overflow}, 32'd0);

        // table walk: R2 R3 R4 R5 R6 R7 R9
        for (int v = 0; v < NV; v++) begin
            bus32 = VECS[v].m32;
            wr_reg(2'd2, VECS[v].thr);
            load_count(VECS[v].start);
            pulse_words(int'(VECS[v].nwords));
            pulse_end();
            check($sformatf("table %0d remaining", v), remaining, VECS[v].exp_rem);
            check($sformatf("table %0d req", v), {31'd0, new_buf_req}, {31'd0, VECS[v].exp_req});
            check($sformatf("table %0d overflow", v), {31'd0, overflow}, {31'd0, VECS[v].exp_ovf});
            if (new_buf_req) give_ack(32'd5000);
        end

        // R12: ack with no request pending is ignored
        bus32 = 1'b0;
        wr_reg(2'd2, 16'd760);
        load_count(32'd2000);
        give_ack(32'h0000_ABCD);
        check("R12 ack ignored count", remaining, 32'd2000);
        check("R12 ack ignored req", {31'd0, new_buf_req}, 32'd0);

        // R9: selector 3 writes nothing
        wr_reg(2'd3, 16'h1234);
        check("R9 sel3 threshold", {16'd0, threshold}, 32'd760);
        check("R9 sel3 count", remaining, 32'd2000);
        // R9: count write wins over same-cycle word strobe
        word_wr = 1'b1;
        wr_reg(2'd0, 16'h0010);
        word_wr = 1'b0;
        check("R9 write priority", remaining, 32'h0000_0010);

        // R11: word and packet end together
        load_count(32'd760);
        word_wr = 1'b1; pkt_end = 1'b1;
        tick();
        word_wr = 1'b0; pkt_end = 1'b0;
        check("R11 count", remaining, 32'd759);
        check("R11 req", {31'd0, new_buf_req}, 32'd1);

        // R10: strobes ignored while waiting; R5 request held
        pulse_words(3);
        pulse_end();
        tick();
        check("R10 count frozen", remaining, 32'd759);
        check("R5 req held", {31'd0, new_buf_req}, 32'd1);

        // R8: acknowledge reloads and drops request
        give_ack(32'h1234_5678);
        check("R8 reload", remaining, 32'h1234_5678);
        check("R8 req drop", {31'd0, new_buf_req}, 32'd0);
        tick();
        check("R8 req stays low", {31'd0, new_buf_req}, 32'd0);

        // R4: overflow sticky across threshold write, cleared by count write
        bus32 = 1'b1;
        load_count(32'd1);
        pulse_words(1);
        check("R4 clamp", remaining, 32'd0);
        check("R4 flag", {31'd0, overflow}, 32'd1);
        wr_reg(2'd2, 16'd100);
        check("R4 sticky", {31'd0, overflow}, 32'd1);
        wr_reg(2'd0, 16'd50);
        check("R4 cleared by write", {31'd0, overflow}, 32'd0);

        // R1: reset from the waiting state
        pulse_end();
        check("R5 below new threshold", {31'd0, new_buf_req}, 32'd1);
        rst_n = 1'b0;
        tick();
        check("R1 reset req", {31'd0, new_buf_req}, 32'd0);
        check("R1 reset threshold", {16'd0, threshold}, 32'h2F8);
        check("R1 reset count", remaining, 32'd0);
        rst_n = 1'b1;
        tick();

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule